// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed W-bit two's complement numbers and returns their 2W-bit signed product. It works over several cycles and takes one recoding step per clock. A pulse on `start` while the block is idle captures both operands. After exactly W clocks a one-cycle `done` pulse marks the product as valid. The product then stays on the output until the next accepted start.

Internally a single shift register holds three parts: an upper accumulator half, a lower half seeded with the multiplier, and one extra bit to the right of the multiplier. That extra bit starts at 0. Each step looks at the lowest multiplier bit together with the extra bit:

- If the pair marks the start of a run of ones, the block subtracts the multiplicand.
- If the pair marks the end of a run, it adds the multiplicand.
- Otherwise it does no arithmetic.

After the arithmetic, the whole register shifts right by one position and the sign is replicated. Negative multipliers therefore need no correction step.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` pulse while `busy` is 0 captures `mcand` and `mplier`, and `busy` is 1 from the next cycle on.
- R3: `done` is high for exactly one cycle. It rises W clock edges after the edge that accepted `start`, and `busy` is 0 in that cycle.
- R4: When `done` is high, `product` equals the signed product mcand × mplier as a 2W-bit two's complement value. For example, 2 × 7 gives 0x0E and 2 × −3 gives 0xFA at W = 4.
- R5: The most negative operand −2^(W−1) gives the correct product both as multiplicand and as multiplier. At W = 4, −8 × −8 = 0x40 and −8 × 7 = 0xC8.
- R6: A `start` while `busy` is 1 is ignored. The running operation completes with its own operands and timing, and no extra `done` follows.
- R7: While the block is idle and `start` is 0, `product` holds its value.
- R8: A `start` in the same cycle as `done` is accepted, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted only when idle |
| mcand | input | W | Multiplicand, two's complement |
| mplier | input | W | Multiplier, two's complement |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: product is valid |
| product | output | 2W | Signed product, held until the next accepted start |

## Verification
The hardest case to reach is an add or subtract whose intermediate result needs one bit more than W. This happens when the multiplicand is the most negative value: subtracting it from a zero accumulator would wrap around in a W-bit adder. The stimulus reaches it by sweeping every operand pair at W = 4, including all pairs with −8 on either side. It also runs directed −128 cases on a second, 8-bit instance. Start requests landing mid-run and in the done cycle are placed at fixed cycle offsets from a known accepted start.

// File: rtl/booth_seq_mult.sv
`timescale 1ns/1ps
module booth_seq_mult #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W:0] ONE = {{W{1'b0}}, 1'b1};

  logic [W-1:0]  acc, mq, md;
  logic          xbit;
  logic [CW-1:0] steps;
  logic [W:0]    acc_x, md_x, sum;

  assign acc_x = {acc[W-1], acc};
  assign md_x  = {md[W-1], md};

  always_comb begin
    case ({mq[0], xbit})
      2'b10:   sum = acc_x + ~md_x + ONE;
      2'b01:   sum = acc_x + md_x;
      default: sum = acc_x;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      mq    <= '0;
      md    <= '0;
      xbit  <= 1'b0;
      steps <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          acc   <= '0;
          mq    <= mplier;
          md    <= mcand;
          xbit  <= 1'b0;
          steps <= CW'(W);
          busy  <= 1'b1;
        end
      end else begin
        acc   <= sum[W:1];
        mq    <= {sum[0], mq[W-1:1]};
        xbit  <= mq[0];
        steps <= steps - 1'b1;
        if (steps == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign product = {acc, mq};
endmodule

// File: rtl/booth_seq_mult_chk.sv
`timescale 1ns/1ps
module booth_seq_mult_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [W-1:0]   mcand,
  input logic [W-1:0]   mplier,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0]        cyc;
  logic [W-1:0]         ca, cb;
  logic signed [2*W-1:0] ea, eb, ep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0;
      ca  <= '0;
      cb  <= '0;
    end else if (start && !busy) begin
      cyc <= CW'(1);
      ca  <= mcand;
      cb  <= mplier;
    end else if (cyc == CW'(W)) begin
      cyc <= '0;
    end else if (cyc != '0) begin
      cyc <= cyc + 1'b1;
    end
  end

  assign ea = {{W{ca[W-1]}}, ca};
  assign eb = {{W{cb[W-1]}}, cb};
  assign ep = ea * eb;

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);                              // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(start));                         // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                         // R3
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CW'(W)) |=> done);                               // R3
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cyc) == CW'(W));                          // R6
  AST_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> product == ep);                                 // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));                 // R7
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.W(W)) u_chk (.*);

// File: tb/test_booth_seq_mult.sv
`timescale 1ns/1ps
module test_booth_seq_mult;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start8 = 1'b0;
  logic [3:0] ma = '0, mb = '0;
  logic [7:0] na = '0, nb = '0;
  logic busy, done, busy8, done8;
  logic [7:0]  prod;
  logic [15:0] prod8;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  booth_seq_mult #(.W(4)) i_booth_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(ma), .mplier(mb),
    .busy(busy), .done(done), .product(prod));

  booth_seq_mult #(.W(8)) i_booth_seq_mult_w8 (
    .clk(clk), .rst_n(rst_n), .start(start8), .mcand(na), .mplier(nb),
    .busy(busy8), .done(done8), .product(prod8));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref4(input logic [3:0] a, input logic [3:0] b);
    int sa = $signed(a);
    int sb = $signed(b);
    int p = sa * sb;
    return p[7:0];
  endfunction

  function automatic logic [15:0] ref8(input logic [7:0] a, input logic [7:0] b);
    int sa = $signed(a);
    int sb = $signed(b);
    int p = sa * sb;
    return p[15:0];
  endfunction

  // drives start at the current negedge; returns at the negedge where done is seen
  task automatic run4(input logic [3:0] a, input logic [3:0] b, output int lat);
    ma = a; mb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    lat = lat - 1;
  endtask

  task automatic run8(input logic [7:0] a, input logic [7:0] b, output int lat);
    na = a; nb = b; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    lat = 1;
    while (!done8 && lat < 30) begin
      @(negedge clk);
      lat++;
    end
    lat = lat - 1;
  endtask

  task automatic t_reset;
    check(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    check(prod == 8'h00, "R1 product", prod, 0);
  endtask

  task automatic t_examples;
    int lat;
    run4(4'd2, 4'd7, lat);
    check(prod == 8'h0E, "R4 2x7", prod, 8'h0E);
    check(lat == 4, "R3 latency", lat, 4);
    @(negedge clk);
    check(done == 0, "R3 single pulse", done, 0);
    run4(4'd2, 4'hD, lat);
    check(prod == 8'hFA, "R4 2x-3", prod, 8'hFA);
  endtask

  task automatic t_start_busy;
    ma = 4'd3; mb = 4'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1, "R2 busy after start", busy, 1);
    repeat (4) @(negedge clk);
    check(busy == 0 && done == 1, "R3 done and idle", {busy, done}, 1);
    check(prod == 8'h0F, "R4 3x5", prod, 8'h0F);
    @(negedge clk);
  endtask

  task automatic t_exhaustive;
    int lat;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        run4(4'(a), 4'(b), lat);
        check(prod == ref4(4'(a), 4'(b)) && lat == 4, "R4 exhaustive",
              prod, ref4(4'(a), 4'(b)));
        @(negedge clk);
      end
  endtask

  task automatic t_extremes;
    int lat;
    run4(4'h8, 4'h8, lat);
    check(prod == 8'h40, "R5 -8x-8", prod, 8'h40);
    @(negedge clk);
    run4(4'h8, 4'h7, lat);
    check(prod == 8'hC8, "R5 -8x7", prod, 8'hC8);
    @(negedge clk);
    run4(4'h7, 4'h8, lat);
    check(prod == 8'hC8, "R5 7x-8", prod, 8'hC8);
    @(negedge clk);
  endtask

  task automatic t_ignore_busy;
    int lat;
    bit extra;
    ma = 4'd6; mb = 4'hB; start = 1'b1;
    @(negedge clk);
    ma = 4'd1; mb = 4'd1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat - 1 == 4, "R6 timing kept", lat - 1, 4);
    check(prod == 8'hE2, "R6 first operands kept", prod, 8'hE2);
    extra = 0;
    repeat (6) begin
      @(negedge clk);
      if (done) extra = 1;
    end
    check(extra == 0 && busy == 0, "R6 no extra done", extra, 0);
  endtask

  task automatic t_hold;
    int lat;
    logic [7:0] snap;
    run4(4'hF, 4'hF, lat);
    snap = prod;
    check(snap == 8'h01, "R4 -1x-1", snap, 8'h01);
    ma = 4'd7; mb = 4'd7;
    repeat (6) @(negedge clk);
    check(prod == snap, "R7 hold while idle", prod, snap);
  endtask

  task automatic t_back_to_back;
    int lat;
    run4(4'd5, 4'hC, lat);
    check(prod == 8'hEC, "R4 5x-4", prod, 8'hEC);
    run4(4'hB, 4'd3, lat);
    check(lat == 4, "R8 back to back latency", lat, 4);
    check(prod == 8'hF1, "R8 back to back product", prod, 8'hF1);
    @(negedge clk);
  endtask

  task automatic t_random8;
    int lat;
    logic [7:0] a, b;
    run8(8'h80, 8'h80, lat);
    check(prod8 == 16'h4000, "R5 W8 -128x-128", prod8, 16'h4000);
    check(lat == 8, "R3 W8 latency", lat, 8);
    @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      a = 8'($urandom);
      b = 8'($urandom);
      run8(a, b, lat);
      check(prod8 == ref8(a, b) && lat == 8, "R4 W8 random", prod8, ref8(a, b));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_examples();
    @(negedge clk);
    t_start_busy();
    t_exhaustive();
    t_extremes();
    t_ignore_busy();
    t_hold();
    t_back_to_back();
    t_random8();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule